// File: doc/BRIEF.md
# Cache Allocation Token Manager

This block lives inside a warp scheduler. It tracks, for every warp slot, whether the warp may run and whether it holds a cache-allocation token. Software sets two values before a kernel starts: how many warp slots are active and how many tokens exist. A slot whose index is at or beyond the active count is throttled. It may be launched, but it is never runnable and never receives a token.

Active warps fall into two groups. A warp holding a token is a regular warp: its L1 misses may allocate lines and evict others. A runnable warp without a token is non-polluting: it may hit, read and write in the L1, but its fills bypass the cache. Tokens are handed out at launch while the pool lasts. A terminating token holder passes its token to the earliest-launched active warp still waiting for one. Each outgoing memory request carries the token bit of the warp that issued it, so the cache can tell whether the request may allocate.

Top module: `cat_token_mgr`

## Requirements
- R1: After reset no warp is runnable and no token is held.
- R2: A config load sets the active count, clamped to the slot count. It sets the token limit to the loaded token count, clamped to the active count. It clears every warp's runnable and token state from the next cycle on.
- R3: A launched warp whose slot index is below the active count is runnable from the cycle after launch. A warp in a slot at or above the active count stays not runnable.
- R4: An active warp being launched gets a token the cycle after launch if held tokens are below the limit. Otherwise it runs without a token.
- R5: A warp in a throttled slot never holds a token.
- R6: A terminate event clears that warp's runnable and token bits the cycle after the event.
- R7: When a token holder terminates, its token goes in the next cycle to the live, active, token-less warp that was launched earliest (lowest launch sequence number). If no warp is waiting, the token returns to the pool.
- R8: req_valid_o follows req_valid_i in the same cycle. req_token_o equals the current token bit of the slot given by req_warp_i.
- R9: The number of held tokens never exceeds the token limit.
- R10: When a launch and a token-holder terminate fall in the same cycle, an already waiting warp takes the released token first. The launching warp draws only on what is left in the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Load active count and token count |
| cfg_active_i | input | 6 | Number of active warp slots |
| cfg_tokens_i | input | 6 | Number of tokens |
| launch_valid_i | input | 1 | Warp launch event |
| launch_warp_i | input | 6 | Slot being launched |
| term_valid_i | input | 1 | Warp terminate event |
| term_warp_i | input | 6 | Slot terminating |
| req_valid_i | input | 1 | Memory request from the scheduler |
| req_warp_i | input | 6 | Slot issuing the request |
| runnable_o | output | 48 | Per-slot runnable bit |
| token_o | output | 48 | Per-slot token bit |
| req_valid_o | output | 1 | Memory request toward the L1 |
| req_token_o | output | 1 | Allocation permission carried with the request |

## Verification
Launch, terminate and config load act through registers. Their effect on runnable_o and token_o is due one clock edge after the event. The bench therefore drives inputs at the falling edge and compares both vectors 2 ns after the following rising edge. The request tag has no register in its path, so it is compared 1 ns after the inputs are driven, within the same cycle. A bench model applies each edge's events in the order the requirements give: terminate, then regrant to the oldest waiter, then launch from the pool.

// File: rtl/cat_pkg.sv
package cat_pkg;
  parameter int unsigned CAT_WARPS = 48;
  parameter int unsigned CAT_SEQ_W = 16;
endpackage

// File: rtl/cat_popcount.sv
module cat_popcount #(
  parameter int unsigned N     = 48,
  parameter int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     bits_i,
  output logic [CNT_W-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < N; i++) count_o = count_o + CNT_W'(bits_i[i]);
  end
endmodule

// File: rtl/cat_oldest_pick.sv
module cat_oldest_pick #(
  parameter int unsigned N     = 48,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            cand_i,
  input  logic [N-1:0][SEQ_W-1:0] seq_i,
  output logic                    found_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [SEQ_W-1:0] best;
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!found_o || seq_i[i] < best)) begin
        found_o = 1'b1;
        best    = seq_i[i];
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cat_token_mgr.sv
module cat_token_mgr
  import cat_pkg::*;
#(
  parameter int unsigned N     = CAT_WARPS,
  parameter int unsigned SEQ_W = CAT_SEQ_W,
  localparam int unsigned IDX_W = $clog2(N),
  localparam int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_load_i,
  input  logic [CNT_W-1:0] cfg_active_i,
  input  logic [CNT_W-1:0] cfg_tokens_i,
  input  logic             launch_valid_i,
  input  logic [IDX_W-1:0] launch_warp_i,
  input  logic             term_valid_i,
  input  logic [IDX_W-1:0] term_warp_i,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] req_warp_i,
  output logic [N-1:0]     runnable_o,
  output logic [N-1:0]     token_o,
  output logic             req_valid_o,
  output logic             req_token_o
);
  logic [N-1:0]            alive_q, token_q, alive_d, token_d, act_mask, term_oh, cand;
  logic [N-1:0][SEQ_W-1:0] seq_q;
  logic [SEQ_W-1:0]        seq_ctr_q;
  logic [CNT_W-1:0]        active_q, limit_q, held, free_cnt, pool, act_clamp, lim_clamp;
  logic                    pick_found, term_tok, regrant, launch_tok;
  logic [IDX_W-1:0]        pick_idx;

  for (genvar g = 0; g < N; g++) begin : g_act
    assign act_mask[g] = CNT_W'(g) < active_q;
  end

  assign term_oh = term_valid_i ? ({{(N-1){1'b0}}, 1'b1} << term_warp_i) : '0;
  assign cand    = alive_q & act_mask & ~token_q & ~term_oh;

  cat_popcount #(.N(N), .CNT_W(CNT_W)) u_held (.bits_i(token_q), .count_o(held));

  cat_oldest_pick #(.N(N), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_pick (
    .cand_i(cand), .seq_i(seq_q), .found_o(pick_found), .idx_o(pick_idx)
  );

  assign act_clamp  = (cfg_active_i > CNT_W'(N)) ? CNT_W'(N) : cfg_active_i;
  assign lim_clamp  = (cfg_tokens_i > act_clamp) ? act_clamp : cfg_tokens_i;
  assign term_tok   = term_valid_i && token_q[term_warp_i];
  assign regrant    = term_tok && pick_found;
  assign free_cnt   = limit_q - held;
  assign pool       = free_cnt + CNT_W'(term_tok && !pick_found);
  assign launch_tok = launch_valid_i && act_mask[launch_warp_i] && (pool != '0);

  // order: release, regrant to oldest waiter, then launch from pool
  always_comb begin
    alive_d = alive_q;
    token_d = token_q;
    if (term_valid_i) begin
      alive_d[term_warp_i] = 1'b0;
      token_d[term_warp_i] = 1'b0;
    end
    if (regrant) token_d[pick_idx] = 1'b1;
    if (launch_valid_i) begin
      alive_d[launch_warp_i] = 1'b1;
      token_d[launch_warp_i] = launch_tok;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alive_q   <= '0;
      token_q   <= '0;
      seq_q     <= '0;
      seq_ctr_q <= '0;
      active_q  <= '0;
      limit_q   <= '0;
    end else if (cfg_load_i) begin
      alive_q   <= '0;
      token_q   <= '0;
      seq_ctr_q <= '0;
      active_q  <= act_clamp;
      limit_q   <= lim_clamp;
    end else begin
      alive_q <= alive_d;
      token_q <= token_d;
      if (launch_valid_i) begin
        seq_q[launch_warp_i] <= seq_ctr_q;
        seq_ctr_q            <= seq_ctr_q + 1'b1;
      end
    end
  end

  assign runnable_o  = alive_q & act_mask;
  assign token_o     = token_q;
  assign req_valid_o = req_valid_i;
  assign req_token_o = token_q[req_warp_i];

  AST_TOKEN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(token_q) <= limit_q) else $error("token limit"); // R9

  AST_TOKEN_THROTTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (token_o & ~runnable_o) == '0) else $error("token on throttled"); // R5

  AST_TERM_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_valid_i && !cfg_load_i && !(launch_valid_i && launch_warp_i == term_warp_i)
    |=> !token_o[$past(term_warp_i)] && !runnable_o[$past(term_warp_i)]) else $error("release"); // R6

  AST_REGRANT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_tok && pick_found && !launch_valid_i && !cfg_load_i
    |=> $countones(token_q) == $past($countones(token_q))) else $error("regrant"); // R7
endmodule

// File: tb/cat_token_mgr_test.sv
`timescale 1ns/1ps
module cat_token_mgr_test;
  localparam int N = 48;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, launch_v = 0, term_v = 0, req_v = 0;
  logic [5:0] cfg_act = 0, cfg_tok = 0, launch_w = 0, term_w = 0, req_w = 0;
  logic [N-1:0] runnable, token;
  logic req_vo, req_to;
  int checks = 0, fails = 0;

  bit m_alive [N];
  bit m_tok [N];
  int m_seq [N];
  int m_ctr = 0, m_act = 0, m_lim = 0;

  always #5 clk = ~clk;

  cat_token_mgr uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_active_i(cfg_act),
    .cfg_tokens_i(cfg_tok), .launch_valid_i(launch_v), .launch_warp_i(launch_w),
    .term_valid_i(term_v), .term_warp_i(term_w), .req_valid_i(req_v), .req_warp_i(req_w),
    .runnable_o(runnable), .token_o(token), .req_valid_o(req_vo), .req_token_o(req_to)
  );

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_run();
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = m_alive[i] && (i < m_act);
    return v;
  endfunction

  function automatic logic [N-1:0] exp_tok();
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = m_tok[i];
    return v;
  endfunction

  task automatic m_step(input bit cl, input int ca, input int ct, input bit lv, input int lw,
                        input bit tv, input int tw);
    int held = 0, free_c, best = -1;
    bit tht;
    if (cl) begin
      for (int i = 0; i < N; i++) begin m_alive[i] = 0; m_tok[i] = 0; end
      m_act = (ca > N) ? N : ca;
      m_lim = (ct > m_act) ? m_act : ct;
      m_ctr = 0;
      return;
    end
    for (int i = 0; i < N; i++) held += m_tok[i];
    free_c = m_lim - held;
    tht = tv && m_tok[tw];
    if (tv) begin m_alive[tw] = 0; m_tok[tw] = 0; end
    if (tht) begin
      for (int i = 0; i < m_act; i++)
        if (m_alive[i] && !m_tok[i] && (best < 0 || m_seq[i] < m_seq[best])) best = i;
      if (best >= 0) m_tok[best] = 1; else free_c++;
    end
    if (lv) begin
      m_alive[lw] = 1;
      m_seq[lw] = m_ctr++;
      m_tok[lw] = (lw < m_act) && (free_c > 0);
    end
  endtask

  task automatic cyc(input bit cl, input int ca, input int ct, input bit lv, input int lw,
                     input bit tv, input int tw, input bit rv, input int rw, input string tag);
    @(negedge clk);
    cfg_load = cl; cfg_act = 6'(ca); cfg_tok = 6'(ct);
    launch_v = lv; launch_w = 6'(lw); term_v = tv; term_w = 6'(tw);
    req_v = rv; req_w = 6'(rw);
    #1;
    chk(req_vo == rv, "R8 req_valid", N'(req_vo), N'(rv));
    if (rv) chk(req_to == m_tok[rw], "R8 req_token", N'(req_to), N'(m_tok[rw]));
    @(posedge clk);
    m_step(cl, ca, ct, lv, lw, tv, tw);
    #2;
    chk(runnable == exp_run(), {tag, " runnable"}, runnable, exp_run());
    chk(token == exp_tok(), {tag, " token"}, token, exp_tok());
    chk($countones(token) <= m_lim, "R9 limit", N'($countones(token)), N'(m_lim));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int seed_v, lw, tw, st;
    bit lv, tv, cl;
    seed_v = $urandom(32'h5eed_c0de);
    repeat (3) @(posedge clk);
    #2;
    chk(runnable == '0 && token == '0, "R1 reset", runnable | token, '0);
    rst_n = 1'b1;
    // R2 clamp of tokens to active count; R3/R5 throttled slot 3
    cyc(1, 3, 10, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 1, 1, 0, 0, 1, 0, "R4");
    cyc(0, 0, 0, 1, 2, 0, 0, 1, 1, "R2");
    cyc(0, 0, 0, 1, 3, 0, 0, 1, 3, "R5");
    chk(token[2] && !runnable[3] && !token[3], "R3 throttle", {token[2], runnable[3], token[3]}, 3'b100);
    // active 6, two tokens, launch out of index order
    cyc(1, 6, 2, 0, 0, 0, 0, 0, 0, "R2");
    chk(runnable == '0 && token == '0, "R2 clear", runnable | token, '0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 1, 1, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 1, 4, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 1, 3, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 1, 2, 0, 0, 1, 4, "R4");
    chk(token[5:0] == 6'b000011, "R4 pool empty", N'(token[5:0]), N'(6'b000011));
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, "R6");
    chk(token[4] && !runnable[1] && !token[1], "R7 oldest by launch", N'(token[5:0]), N'(6'b010001));
    cyc(0, 0, 0, 1, 1, 1, 4, 1, 1, "R10");
    chk(token[3] && !token[1], "R10 waiter first", N'(token[5:0]), N'(6'b001001));
    cyc(0, 0, 0, 0, 0, 1, 2, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 1, 3, 0, 0, "R7");
    cyc(0, 0, 0, 1, 5, 0, 0, 1, 5, "R7");
    chk(token[5] && token[0], "R7 pool return", N'(token[5:0]), N'(6'b100001));
    // constrained random
    cyc(1, 40, 12, 0, 0, 0, 0, 0, 0, "R2");
    for (int c = 0; c < 4000; c++) begin
      cl = ($urandom % 300) == 0;
      lv = 0; tv = 0; lw = 0; tw = 0;
      if (($urandom % 10) < 6) begin
        st = $urandom % N;
        for (int k = 0; k < N; k++)
          if (!lv && !m_alive[(st + k) % N]) begin lv = 1; lw = (st + k) % N; end
      end
      if (($urandom % 10) < 4) begin
        st = $urandom % N;
        for (int k = 0; k < N; k++)
          if (!tv && m_alive[(st + k) % N] && ((st + k) % N) != lw) begin tv = 1; tw = (st + k) % N; end
      end
      cyc(cl, $urandom % 64, $urandom % 64, lv, lw, tv, tw, $urandom % 2, $urandom % N,
          tv ? "R7" : (lv ? "R4" : "R3"));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule